// File: doc/BRIEF.md
# Calendar Time Keeper Registers

This block is a real-time clock core that keeps seconds, minutes, hours, day of month, month and year. A one-cycle pulse on `tick_1s` advances the time by one second, and a carry out of 23:59:59 moves the calendar forward by one day. Software sees the clock through three 32-bit words on a single-cycle memory-mapped port: a status word, a date word and a time word. A read returns the live counter value in the same cycle, with no snapshot, so two reads can see different values.

A write to the time word or the date word does not change the running counter at once. The value is held as pending, and the matching busy flag in the status word is set. On the next second tick the pending value replaces the counter and the flag clears. The calendar does not work out leap years from the year. Software writes a leap flag along with the date, and February uses that flag to choose between 28 and 29 days. The year is a 6-bit offset from 2010, so it covers 2010 to 2073.

Top module: `caltime_regs`

## Requirements
- R1: After reset the time reads 00:00:00. The date reads day 1, month 1, year offset 0, with the leap flag clear. Both busy flags read 0.
- R2: Offset 0x00 is the status word, with the time busy flag at bit 8 and the date busy flag at bit 7. Offset 0x04 is the date word: day [4:0], month [11:8], year offset [21:16], leap flag [22]. Offset 0x08 is the time word: seconds [5:0], minutes [13:8], hours [20:16]. All other bits read 0, and any other offset reads 0.
- R3: A write to the time word or the date word sets the matching busy flag from the next cycle. The visible counter keeps its old value until a tick arrives.
- R4: On the next tick after such a write, the pending value becomes the counter value and the busy flag clears in that same cycle. A loaded time word produces no day carry.
- R5: A second write to a word that is still busy replaces the pending value. Only the last value written is applied, and the flag clears after that one tick.
- R6: With no tick the counters hold. Each tick adds one second.
- R7: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry one day into the calendar.
- R8: Months 4, 6, 9 and 11 end at day 30. Months 1, 3, 5, 7, 8, 10 and 12 end at day 31. After the last day the next day is day 1 of the next month.
- R9: February ends at day 29 when the stored leap flag is 1 and at day 28 when it is 0.
- R10: After day 31 of month 12 the year offset increments and the date becomes month 1, day 1. Year offset 63 wraps to 0. The leap flag keeps its stored value across these rollovers.
- R11: Writes to the status word or to an unmapped offset have no effect on the counters or on the busy flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_1s | input | 1 | One-cycle pulse, one per second |
| bus_addr | input | 8 | Byte offset of the word accessed |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Live read data for `bus_addr`, combinational |

## Verification
A wrong carry or month-length decision puts a bad field into the date or time word on the tick where it happens. The bench loads values one second before each boundary, so such an error shows up on the read that follows that tick. A pending value that is lost or applied early shows up as a wrong live time or date word before the tick, or as a busy flag that does not clear after it. A stale leap flag shows up as February ending on the wrong day. In every case the fault is visible at the ports within two ticks of the stimulus.

// File: rtl/caltime_pkg.sv
package caltime_pkg;
  localparam int YEAR_W = 6;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_DATE = 8'h04;
  localparam logic [7:0] OFS_TIME = 8'h08;

  localparam int CTRL_TBUSY_BIT = 8;
  localparam int CTRL_DBUSY_BIT = 7;

  localparam int DT_DAY_LSB  = 0;
  localparam int DT_MON_LSB  = 8;
  localparam int DT_YEAR_LSB = 16;
  localparam int DT_LEAP_BIT = 22;

  localparam int TM_SEC_LSB = 0;
  localparam int TM_MIN_LSB = 8;
  localparam int TM_HR_LSB  = 16;

  typedef struct packed {
    logic [4:0] hr;
    logic [5:0] mn;
    logic [5:0] sc;
  } hms_t;

  typedef struct packed {
    logic              leap;
    logic [YEAR_W-1:0] yr;
    logic [3:0]        mo;
    logic [4:0]        dy;
  } ymd_t;

  localparam int HMS_W = $bits(hms_t);
  localparam int YMD_W = $bits(ymd_t);
endpackage

// File: rtl/caltime_shadow.sv
module caltime_shadow #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         tick,
  output logic [W-1:0] pend_data,
  output logic         busy,
  output logic         apply
);
  logic [W-1:0] pend_nxt;
  logic         busy_nxt;
  logic         reg_en;

  assign apply  = tick & busy;
  assign reg_en = wr_en | tick;

  always_comb begin
    pend_nxt = pend_data;
    busy_nxt = busy;
    if (wr_en) begin
      pend_nxt = wr_data;
      busy_nxt = 1'b1;
    end else if (tick) begin
      busy_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_data <= '0;
      busy      <= 1'b0;
    end else if (reg_en) begin
      pend_data <= pend_nxt;
      busy      <= busy_nxt;
    end
  end

  AST_WRITE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> busy); // R3
  AST_TICK_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && busy && !wr_en) |=> !busy); // R4
  AST_REWRITE_KEEPS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (pend_data == $past(wr_data))); // R5
endmodule

// File: rtl/caltime_clock.sv
module caltime_clock
  import caltime_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic load,
  input  hms_t load_val,
  output hms_t cur,
  output logic day_carry
);
  hms_t nxt;
  logic sec_end;
  logic min_end;
  logic hr_end;

  assign sec_end = (cur.sc == 6'd59);
  assign min_end = (cur.mn == 6'd59);
  assign hr_end  = (cur.hr == 5'd23);

  always_comb begin
    nxt       = cur;
    day_carry = 1'b0;
    if (load) begin
      nxt = load_val;
    end else if (tick) begin
      if (!sec_end) begin
        nxt.sc = cur.sc + 6'd1;
      end else begin
        nxt.sc = '0;
        if (!min_end) begin
          nxt.mn = cur.mn + 6'd1;
        end else begin
          nxt.mn = '0;
          if (!hr_end) begin
            nxt.hr = cur.hr + 5'd1;
          end else begin
            nxt.hr    = '0;
            day_carry = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0;
    end else if (tick) begin
      cur <= nxt;
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cur)); // R6
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cur.sc == 6'd59) |=> (cur.sc == 6'd0)); // R7
  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cur.sc < 6'd59) |=> (cur.sc == $past(cur.sc) + 6'd1)); // R6
endmodule

// File: rtl/caltime_date.sv
module caltime_date
  import caltime_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic load,
  input  ymd_t load_val,
  output ymd_t cur
);
  ymd_t       nxt;
  logic [4:0] last_day;
  logic       reg_en;

  assign reg_en = adv | load;

  always_comb begin
    case (cur.mo)
      4'd2:                      last_day = cur.leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   last_day = 5'd30;
      default:                   last_day = 5'd31;
    endcase
  end

  always_comb begin
    nxt = cur;
    if (load) begin
      nxt = load_val;
    end else if (adv) begin
      if (cur.dy < last_day) begin
        nxt.dy = cur.dy + 5'd1;
      end else begin
        nxt.dy = 5'd1;
        if (cur.mo >= 4'd12) begin
          nxt.mo = 4'd1;
          nxt.yr = cur.yr + 1'b1;
        end else begin
          nxt.mo = cur.mo + 4'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur.leap <= 1'b0;
      cur.yr   <= '0;
      cur.mo   <= 4'd1;
      cur.dy   <= 5'd1;
    end else if (reg_en) begin
      cur <= nxt;
    end
  end

  AST_FEB_LEAP_DAY: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && cur.mo == 4'd2 && cur.dy == 5'd28 && cur.leap) |=> (cur.dy == 5'd29)); // R9
  AST_FEB_PLAIN_END: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && cur.mo == 4'd2 && cur.dy == 5'd28 && !cur.leap) |=> (cur.mo == 4'd3 && cur.dy == 5'd1)); // R9
  AST_LEAP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!load) |=> (cur.leap == $past(cur.leap))); // R10
endmodule

// File: rtl/caltime_regs.sv
module caltime_regs
  import caltime_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1s,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe[1];

  logic sel_ctrl, sel_date, sel_time;
  assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_date = (bus_addr == ADDR_W'(OFS_DATE));
  assign sel_time = (bus_addr == ADDR_W'(OFS_TIME));

  hms_t wr_hms;
  ymd_t wr_ymd;
  always_comb begin
    wr_hms.hr   = bus_wdata[TM_HR_LSB +: 5];
    wr_hms.mn   = bus_wdata[TM_MIN_LSB +: 6];
    wr_hms.sc   = bus_wdata[TM_SEC_LSB +: 6];
    wr_ymd.leap = bus_wdata[DT_LEAP_BIT];
    wr_ymd.yr   = bus_wdata[DT_YEAR_LSB +: YEAR_W];
    wr_ymd.mo   = bus_wdata[DT_MON_LSB +: 4];
    wr_ymd.dy   = bus_wdata[DT_DAY_LSB +: 5];
  end

  logic [HMS_W-1:0] pend_t_bits;
  logic [YMD_W-1:0] pend_d_bits;
  logic busy_t, busy_d, apply_t, apply_d;

  caltime_shadow #(.W(HMS_W)) u_shadow_time (
    .clk(clk), .rst_n(rst_core_n), .wr_en(bus_wen & sel_time),
    .wr_data(wr_hms), .tick(tick_1s), .pend_data(pend_t_bits),
    .busy(busy_t), .apply(apply_t)
  );

  caltime_shadow #(.W(YMD_W)) u_shadow_date (
    .clk(clk), .rst_n(rst_core_n), .wr_en(bus_wen & sel_date),
    .wr_data(wr_ymd), .tick(tick_1s), .pend_data(pend_d_bits),
    .busy(busy_d), .apply(apply_d)
  );

  hms_t now_hms;
  ymd_t now_ymd;
  logic day_carry;

  caltime_clock u_clock (
    .clk(clk), .rst_n(rst_core_n), .tick(tick_1s), .load(apply_t),
    .load_val(hms_t'(pend_t_bits)), .cur(now_hms), .day_carry(day_carry)
  );

  caltime_date u_date (
    .clk(clk), .rst_n(rst_core_n), .adv(day_carry), .load(apply_d),
    .load_val(ymd_t'(pend_d_bits)), .cur(now_ymd)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl) begin
      bus_rdata[CTRL_TBUSY_BIT] = busy_t;
      bus_rdata[CTRL_DBUSY_BIT] = busy_d;
    end else if (sel_date) begin
      bus_rdata[DT_LEAP_BIT]            = now_ymd.leap;
      bus_rdata[DT_YEAR_LSB +: YEAR_W]  = now_ymd.yr;
      bus_rdata[DT_MON_LSB +: 4]        = now_ymd.mo;
      bus_rdata[DT_DAY_LSB +: 5]        = now_ymd.dy;
    end else if (sel_time) begin
      bus_rdata[TM_HR_LSB +: 5]  = now_hms.hr;
      bus_rdata[TM_MIN_LSB +: 6] = now_hms.mn;
      bus_rdata[TM_SEC_LSB +: 6] = now_hms.sc;
    end
  end

  AST_TIME_LOADS_PENDING: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tick_1s && busy_t) |=> (now_hms == $past(pend_t_bits))); // R4
  AST_DATE_LOADS_PENDING: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tick_1s && busy_d) |=> (now_ymd == $past(pend_d_bits))); // R4
  AST_WRITE_NOT_VISIBLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_wen && sel_time && !tick_1s) |=> (now_hms == $past(now_hms))); // R3
endmodule

// File: tb/caltime_regs_test.sv
module caltime_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1s = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_wen = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int total = 0;
  int bad = 0;

  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_DATE = 8'h04;
  localparam logic [7:0] A_TIME = 8'h08;

  caltime_regs uut (
    .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .bus_addr(bus_addr),
    .bus_wen(bus_wen), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] tw(int h, int m, int s);
    return (32'(h) << 16) | (32'(m) << 8) | 32'(s);
  endfunction

  function automatic logic [31:0] dw(int lp, int y, int mo, int d);
    return (32'(lp) << 22) | (32'(y) << 16) | (32'(mo) << 8) | 32'(d);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic tk();
    @(negedge clk);
    tick_1s = 1'b1;
    @(negedge clk);
    tick_1s = 1'b0;
  endtask

  task automatic set_both(logic [31:0] t, logic [31:0] d);
    wr(A_TIME, t);
    wr(A_DATE, d);
    tk();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_TIME, v); check("R1 time", v, 32'h0);
    rd(A_DATE, v); check("R1 date", v, dw(0, 0, 1, 1));
    rd(A_CTRL, v); check("R1 busy", v, 32'h0);
    rd(8'h0C, v);  check("R2 unmapped read", v, 32'h0);
  endtask

  task automatic t_busy_load();
    logic [31:0] v;
    wr(A_TIME, tw(10, 20, 30));
    rd(A_CTRL, v); check("R3 time busy bit8", v, 32'h100);
    rd(A_TIME, v); check("R3 time not yet applied", v, 32'h0);
    wr(A_DATE, dw(1, 14, 7, 9) | 32'hFF80_E0E0);
    rd(A_CTRL, v); check("R3 both busy", v, 32'h180);
    rd(A_DATE, v); check("R3 date not yet applied", v, dw(0, 0, 1, 1));
    repeat (5) @(negedge clk);
    rd(A_TIME, v); check("R6 hold without tick", v, 32'h0);
    tk();
    rd(A_TIME, v); check("R4 time applied", v, tw(10, 20, 30));
    rd(A_DATE, v); check("R4 R2 date applied, spare bits dropped", v, dw(1, 14, 7, 9));
    rd(A_CTRL, v); check("R4 busy cleared", v, 32'h0);
    tk();
    rd(A_TIME, v); check("R6 one second", v, tw(10, 20, 31));
  endtask

  task automatic t_rewrite();
    logic [31:0] v;
    wr(A_TIME, tw(1, 1, 1));
    wr(A_TIME, tw(2, 2, 2));
    tk();
    rd(A_TIME, v); check("R5 last write applied", v, tw(2, 2, 2));
    rd(A_CTRL, v); check("R5 busy cleared", v, 32'h0);
    tk();
    rd(A_TIME, v); check("R5 single update", v, tw(2, 2, 3));
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    wr(A_CTRL, 32'hFFFF_FFFF);
    wr(8'h0C, 32'h0012_3456);
    rd(A_CTRL, v); check("R11 busy untouched", v, 32'h0);
    tk();
    rd(A_TIME, v); check("R11 time only ticked", v, tw(2, 2, 4));
    rd(A_DATE, v); check("R11 date untouched", v, dw(1, 14, 7, 9));
  endtask

  task automatic t_carries();
    logic [31:0] v;
    set_both(tw(0, 0, 59), dw(0, 3, 5, 10));
    tk(); rd(A_TIME, v); check("R7 sec carry", v, tw(0, 1, 0));
    wr(A_TIME, tw(4, 59, 59)); tk();
    tk(); rd(A_TIME, v); check("R7 min carry", v, tw(5, 0, 0));
    rd(A_DATE, v); check("R7 no day carry", v, dw(0, 3, 5, 10));
    wr(A_TIME, tw(23, 59, 59)); tk();
    rd(A_DATE, v); check("R4 loaded time no carry", v, dw(0, 3, 5, 10));
    tk(); rd(A_TIME, v); check("R7 hour wrap", v, tw(0, 0, 0));
    rd(A_DATE, v); check("R7 day carry", v, dw(0, 3, 5, 11));
  endtask

  task automatic t_month(string req, int lp, int mo, int d, int emo, int ed);
    logic [31:0] v;
    set_both(tw(23, 59, 59), dw(lp, 7, mo, d));
    tk();
    rd(A_DATE, v); check(req, v, dw(lp, 7, emo, ed));
  endtask

  task automatic t_year();
    logic [31:0] v;
    set_both(tw(23, 59, 59), dw(1, 5, 12, 31));
    tk(); rd(A_DATE, v); check("R10 year increment, leap kept", v, dw(1, 6, 1, 1));
    set_both(tw(23, 59, 59), dw(0, 63, 12, 31));
    tk(); rd(A_DATE, v); check("R10 year wrap", v, dw(0, 0, 1, 1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R1..R11 run hung");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_busy_load();
    t_rewrite();
    t_ignored();
    t_carries();
    t_month("R8 Apr 30 ends", 0, 4, 30, 5, 1);
    t_month("R8 Nov 30 ends", 0, 11, 30, 12, 1);
    t_month("R8 Jan 30 continues", 0, 1, 30, 1, 31);
    t_month("R8 Jan 31 ends", 0, 1, 31, 2, 1);
    t_month("R9 leap Feb 28 continues", 1, 2, 28, 2, 29);
    t_month("R9 leap Feb 29 ends", 1, 2, 29, 3, 1);
    t_month("R9 plain Feb 28 ends", 0, 2, 28, 3, 1);
    t_year();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule